// File: doc/BRIEF.md
# Two-channel real spectrum separator

This block sits after a complex FFT that was fed two real signals at once: channel A on the real input and channel B on the imaginary input. It takes the resulting mixed spectrum X, one bin per valid cycle in ascending order 0 to N-1, and keeps the whole frame in an internal store. Once bin N-1 has arrived, it reads bin i together with its mirror bin N-i and uses conjugate symmetry to rebuild the two separate spectra. For each index from 0 to N/2 it emits one pair of bins, one for A and one for B, at a rate of one pair per clock.

Each sum or difference is formed one bit wider than the data and then shifted right arithmetically by one, so the halving never overflows. The DC and Nyquist bins of a real signal have no imaginary part. The block therefore uses a packed format: the imaginary slot of each channel's bin 0 carries that channel's real Nyquist value, and the imaginary parts at bin N/2 are driven to zero. The 4-bit block-floating exponent that arrives with bin 0 of a frame is passed through unchanged on every output bin of that frame. A start flag marks bin 0 of each output frame, and a done pulse follows bin N/2. Input offered while a frame is being emitted is dropped.

Top module: `spec_split`

## Requirements
- R1: After reset, out_valid, out_start and out_done are low.
- R2: For 1 <= i <= N/2-1, a_re = (XRe[i] + XRe[N-i]) >>> 1 and a_im = (XIm[i] - XIm[N-i]) >>> 1, with the sum or difference formed one bit wider than the data and rounded toward minus infinity.
- R3: For 1 <= i <= N/2-1, b_re = (XIm[i] + XIm[N-i]) >>> 1 and b_im = (XRe[N-i] - XRe[i]) >>> 1, formed and rounded the same way as in R2.
- R4: At index 0, a_re = XRe[0], b_re = XIm[0], a_im = XRe[N/2] and b_im = XIm[N/2].
- R5: At index N/2, a_re = XRe[N/2], b_re = XIm[N/2], and a_im = b_im = 0.
- R6: Full-scale inputs (+max and -min of the DW-bit two's-complement range) give results that are exact per R2 and R3, with no wrap-around.
- R7: On every output bin of a frame, out_exp equals the in_exp value presented with bin 0 of that frame.
- R8: Input bins are written in the order 0 to N-1. The first output appears on the second rising edge after the edge that writes bin N-1. Outputs then follow on consecutive cycles with out_idx running 0, 1, ..., N/2.
- R9: out_start is high only together with the bin at out_idx 0. out_done is high for exactly one cycle, the cycle right after the bin at N/2, and out_valid is low in that cycle.
- R10: in_valid is ignored from the edge that writes bin N-1 until the last output bin has been produced. Neither the frame being emitted nor the next frame is affected, and the next frame starts at bin 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input bin strobe |
| in_re | input | DW | Real part of mixed spectrum bin |
| in_im | input | DW | Imaginary part of mixed spectrum bin |
| in_exp | input | 4 | Frame exponent, sampled with bin 0 |
| out_valid | output | 1 | Output bin pair valid |
| out_start | output | 1 | Marks output bin 0 |
| out_done | output | 1 | One-cycle pulse after output bin N/2 |
| out_idx | output | LOG2N | Output bin index 0..N/2 |
| a_re | output | DW | Channel A real part |
| a_im | output | DW | Channel A imaginary part (Nyquist real at bin 0) |
| b_re | output | DW | Channel B real part |
| b_im | output | DW | Channel B imaginary part (Nyquist real at bin 0) |
| out_exp | output | 4 | Exponent passed through |

## Verification
Bin 0 is due on the second rising edge after the edge that writes input bin N-1. One cycle of that delay is the registered store read and one is the output register. Bin j follows j cycles after bin 0, and the done pulse follows one cycle after bin N/2. Each scenario task drives inputs on falling edges and then samples on falling edges, counted from that final write. The first sample must show no output, and each later sample must show exactly the bin that is due. Dropped input is driven only inside the window in which the block must ignore it.

// File: rtl/ss_pkg.sv
package ss_pkg;
  localparam int EXP_W = 4;

  typedef enum logic [1:0] {
    BIN_DC  = 2'd0,
    BIN_MID = 2'd1,
    BIN_NYQ = 2'd2
  } bin_kind_t;

  typedef enum logic {
    ST_FILL = 1'b0,
    ST_EMIT = 1'b1
  } seq_state_t;
endpackage

// File: rtl/ss_ram.sv
module ss_ram #(
  parameter int W  = 32,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd,
  input  logic          re,
  input  logic [AW-1:0] ra,
  output logic [W-1:0]  rq
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
  end

  always_ff @(posedge clk) begin
    if (re) rq <= mem[ra];
  end
endmodule

// File: rtl/ss_seq.sv
module ss_seq import ss_pkg::*; #(
  parameter int LOG2N = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             wr_en,
  output logic [LOG2N-1:0] wr_addr,
  output logic             cap_exp,
  output logic             rd_v,
  output logic [LOG2N-1:0] rd_addr0,
  output logic [LOG2N-1:0] rd_addr1,
  output logic             s1_v,
  output bin_kind_t        s1_kind,
  output logic [LOG2N-1:0] s1_idx
);
  localparam int N = 1 << LOG2N;
  localparam logic [LOG2N-1:0] HALF = LOG2N'(N / 2);
  localparam logic [LOG2N-1:0] LAST = LOG2N'(N - 1);

  seq_state_t       state;
  logic [LOG2N-1:0] wcnt;
  logic [LOG2N-1:0] rcnt;
  bin_kind_t        kind;

  always_comb begin
    wr_en    = (state == ST_FILL) && in_valid;
    wr_addr  = wcnt;
    cap_exp  = wr_en && (wcnt == '0);
    rd_v     = (state == ST_EMIT);
    rd_addr0 = rcnt;
    // mirror bin N-i; bin 0 fetches the Nyquist bin for packing
    rd_addr1 = (rcnt == '0) ? HALF : (~rcnt + 1'b1);
    if (rcnt == '0)       kind = BIN_DC;
    else if (rcnt == HALF) kind = BIN_NYQ;
    else                  kind = BIN_MID;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_FILL;
      wcnt  <= '0;
      rcnt  <= '0;
    end else begin
      case (state)
        ST_FILL: begin
          if (in_valid) begin
            wcnt <= wcnt + 1'b1;
            if (wcnt == LAST) begin
              state <= ST_EMIT;
              rcnt  <= '0;
            end
          end
        end
        default: begin
          if (rcnt == HALF) state <= ST_FILL;
          else              rcnt  <= rcnt + 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v    <= 1'b0;
      s1_kind <= BIN_DC;
      s1_idx  <= '0;
    end else begin
      s1_v    <= rd_v;
      s1_kind <= kind;
      s1_idx  <= rcnt;
    end
  end

  // R10: a new fill always begins from bin 0
  a_r10_fill_from_zero: assert property (@(posedge clk) disable iff (rst)
    $fell(rd_v) |-> (wcnt == '0));

  // R8: the read phase issues exactly N/2+1 addresses, then stops
  a_r8_read_len: assert property (@(posedge clk) disable iff (rst)
    (rd_v && rcnt == HALF) |=> !rd_v);
endmodule

// File: rtl/ss_math.sv
module ss_math import ss_pkg::*; #(
  parameter int DW    = 16,
  parameter int LOG2N = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    s1_v,
  input  bin_kind_t               s1_kind,
  input  logic [LOG2N-1:0]        s1_idx,
  input  logic signed [DW-1:0]    p_re,
  input  logic signed [DW-1:0]    p_im,
  input  logic signed [DW-1:0]    q_re,
  input  logic signed [DW-1:0]    q_im,
  input  logic                    cap_exp,
  input  logic [EXP_W-1:0]        in_exp,
  output logic                    out_valid,
  output logic                    out_start,
  output logic                    out_done,
  output logic [LOG2N-1:0]        out_idx,
  output logic signed [DW-1:0]    a_re,
  output logic signed [DW-1:0]    a_im,
  output logic signed [DW-1:0]    b_re,
  output logic signed [DW-1:0]    b_im,
  output logic [EXP_W-1:0]        out_exp
);
  localparam int N = 1 << LOG2N;
  localparam logic [LOG2N-1:0] HALF = LOG2N'(N / 2);

  function automatic logic signed [DW-1:0] halve(
    input logic signed [DW-1:0] x, input logic signed [DW-1:0] y,
    input logic sub);
    logic [DW:0] t;
    if (sub) t = {x[DW-1], x} - {y[DW-1], y};
    else     t = {x[DW-1], x} + {y[DW-1], y};
    return t[DW:1];
  endfunction

  logic [EXP_W-1:0]     exp_q;
  logic signed [DW-1:0] n_are, n_aim, n_bre, n_bim;

  always_comb begin
    case (s1_kind)
      BIN_DC: begin
        n_are = p_re;  n_aim = q_re;
        n_bre = p_im;  n_bim = q_im;
      end
      BIN_NYQ: begin
        n_are = p_re;  n_aim = '0;
        n_bre = p_im;  n_bim = '0;
      end
      default: begin
        n_are = halve(p_re, q_re, 1'b0);
        n_aim = halve(p_im, q_im, 1'b1);
        n_bre = halve(p_im, q_im, 1'b0);
        n_bim = halve(q_re, p_re, 1'b1);
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) exp_q <= '0;
    else if (cap_exp) exp_q <= in_exp;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_start <= 1'b0;
      out_done  <= 1'b0;
      out_idx   <= '0;
      a_re      <= '0;
      a_im      <= '0;
      b_re      <= '0;
      b_im      <= '0;
      out_exp   <= '0;
    end else begin
      out_valid <= s1_v;
      out_start <= s1_v && (s1_kind == BIN_DC);
      out_done  <= out_valid && (out_idx == HALF);
      if (s1_v) begin
        out_idx <= s1_idx;
        a_re    <= n_are;
        a_im    <= n_aim;
        b_re    <= n_bre;
        b_im    <= n_bim;
        out_exp <= exp_q;
      end
    end
  end

  // R9: start only accompanies the bin at index 0
  a_r9_start_bin0: assert property (@(posedge clk) disable iff (rst)
    out_start |-> (out_valid && out_idx == '0));

  // R9: done follows the Nyquist bin in a cycle with no valid output
  a_r9_done_after_nyq: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_idx == HALF) |=> (out_done && !out_valid));

  // R8: indices advance by one on consecutive cycles
  a_r8_idx_step: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_idx != HALF) |=> (out_valid && out_idx == $past(out_idx) + 1'b1));

  // R5: imaginary outputs at Nyquist are zero
  a_r5_nyq_imag_zero: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_idx == HALF) |-> (a_im == '0 && b_im == '0));

  // R7: exponent holds across a frame
  a_r7_exp_steady: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_start && $past(out_valid)) |-> $stable(out_exp));
endmodule

// File: rtl/spec_split.sv
module spec_split import ss_pkg::*; #(
  parameter int DW    = 16,
  parameter int LOG2N = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_re,
  input  logic signed [DW-1:0] in_im,
  input  logic [3:0]           in_exp,
  output logic                 out_valid,
  output logic                 out_start,
  output logic                 out_done,
  output logic [LOG2N-1:0]     out_idx,
  output logic signed [DW-1:0] a_re,
  output logic signed [DW-1:0] a_im,
  output logic signed [DW-1:0] b_re,
  output logic signed [DW-1:0] b_im,
  output logic [3:0]           out_exp
);
  localparam int WW = 2 * DW;

  logic             wr_en, cap_exp, rd_v, s1_v;
  logic [LOG2N-1:0] wr_addr, rd_addr0, rd_addr1, s1_idx;
  bin_kind_t        s1_kind;
  logic [LOG2N-1:0] bank_ra [2];
  logic [WW-1:0]    bank_q  [2];

  ss_seq #(.LOG2N(LOG2N)) u_seq (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .wr_en(wr_en), .wr_addr(wr_addr), .cap_exp(cap_exp),
    .rd_v(rd_v), .rd_addr0(rd_addr0), .rd_addr1(rd_addr1),
    .s1_v(s1_v), .s1_kind(s1_kind), .s1_idx(s1_idx)
  );

  assign bank_ra[0] = rd_addr0;
  assign bank_ra[1] = rd_addr1;

  // two copies of the frame so bin i and its mirror read in one cycle
  for (genvar g = 0; g < 2; g++) begin : g_bank
    ss_ram #(.W(WW), .AW(LOG2N)) u_ram (
      .clk(clk), .we(wr_en), .wa(wr_addr), .wd({in_re, in_im}),
      .re(rd_v), .ra(bank_ra[g]), .rq(bank_q[g])
    );
  end

  ss_math #(.DW(DW), .LOG2N(LOG2N)) u_math (
    .clk(clk), .rst(rst), .s1_v(s1_v), .s1_kind(s1_kind), .s1_idx(s1_idx),
    .p_re(bank_q[0][WW-1:DW]), .p_im(bank_q[0][DW-1:0]),
    .q_re(bank_q[1][WW-1:DW]), .q_im(bank_q[1][DW-1:0]),
    .cap_exp(cap_exp), .in_exp(in_exp),
    .out_valid(out_valid), .out_start(out_start), .out_done(out_done),
    .out_idx(out_idx), .a_re(a_re), .a_im(a_im), .b_re(b_re), .b_im(b_im),
    .out_exp(out_exp)
  );
endmodule

// File: tb/spec_split_test.sv
`timescale 1ns/1ps
module spec_split_test;
  localparam int DW = 16;
  localparam int LOG2N = 4;
  localparam int N = 1 << LOG2N;
  localparam int H = N / 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic signed [DW-1:0] in_re = '0, in_im = '0;
  logic [3:0] in_exp = '0;
  logic out_valid, out_start, out_done;
  logic [LOG2N-1:0] out_idx;
  logic signed [DW-1:0] a_re, a_im, b_re, b_im;
  logic [3:0] out_exp;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  int xr [N];
  int xi [N];

  always #2 clk = ~clk;

  spec_split #(.DW(DW), .LOG2N(LOG2N)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_re(in_re), .in_im(in_im),
    .in_exp(in_exp), .out_valid(out_valid), .out_start(out_start),
    .out_done(out_done), .out_idx(out_idx), .a_re(a_re), .a_im(a_im),
    .b_re(b_re), .b_im(b_im), .out_exp(out_exp)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int e_are(input int i);
    if (i == 0 || i == H) return xr[i];
    return (xr[i] + xr[N-i]) >>> 1;
  endfunction
  function automatic int e_aim(input int i);
    if (i == 0) return xr[H];
    if (i == H) return 0;
    return (xi[i] - xi[N-i]) >>> 1;
  endfunction
  function automatic int e_bre(input int i);
    if (i == 0 || i == H) return xi[i];
    return (xi[i] + xi[N-i]) >>> 1;
  endfunction
  function automatic int e_bim(input int i);
    if (i == 0) return xi[H];
    if (i == H) return 0;
    return (xr[N-i] - xr[i]) >>> 1;
  endfunction

  // drive one frame, then check every output bin at its due cycle
  task automatic run_frame(input logic [3:0] ex, input string ta,
                           input string tb, input bit junk);
    for (int k = 0; k < N; k++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_re = DW'(xr[k]);
      in_im = DW'(xi[k]);
      in_exp = (k == 0) ? ex : 4'(k);
    end
    @(negedge clk);                 // after write edge of bin N-1
    in_valid = junk;
    in_re = DW'($urandom);
    in_im = DW'($urandom);
    in_exp = 4'($urandom);
    chk("R8 no output yet", int'(out_valid), 0);
    @(negedge clk);                 // one edge later: still no output
    chk("R8 latency", int'(out_valid), 0);
    for (int j = 0; j <= H; j++) begin
      @(negedge clk);
      in_valid = junk && (j < H - 1);
      in_re = DW'($urandom);
      in_im = DW'($urandom);
      chk("R8 valid", int'(out_valid), 1);
      chk("R8 index", int'(out_idx), j);
      chk("R9 start", int'(out_start), (j == 0) ? 1 : 0);
      chk("R9 no early done", int'(out_done), 0);
      chk("R7 exponent", int'(out_exp), int'(ex));
      if (j == 0) begin
        chk("R4 a_re", int'(a_re), e_are(j));
        chk("R4 a_im", int'(a_im), e_aim(j));
        chk("R4 b_re", int'(b_re), e_bre(j));
        chk("R4 b_im", int'(b_im), e_bim(j));
      end else if (j == H) begin
        chk("R5 a_re", int'(a_re), e_are(j));
        chk("R5 a_im", int'(a_im), 0);
        chk("R5 b_re", int'(b_re), e_bre(j));
        chk("R5 b_im", int'(b_im), 0);
      end else begin
        chk({ta, " a_re"}, int'(a_re), e_are(j));
        chk({ta, " a_im"}, int'(a_im), e_aim(j));
        chk({tb, " b_re"}, int'(b_re), e_bre(j));
        chk({tb, " b_im"}, int'(b_im), e_bim(j));
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    chk("R9 done pulse", int'(out_done), 1);
    chk("R9 no valid with done", int'(out_valid), 0);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 valid", int'(out_valid), 0);
    chk("R1 start", int'(out_start), 0);
    chk("R1 done", int'(out_done), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 idle valid", int'(out_valid), 0);
  endtask

  task automatic t_ramp();
    for (int k = 0; k < N; k++) begin
      xr[k] = 100 * k - 700;
      xi[k] = 37 * k * k - 3000;
    end
    run_frame(4'd5, "R2", "R3", 1'b0);
  endtask

  task automatic t_full_scale();
    for (int k = 0; k < N; k++) begin
      xr[k] = (k < H) ? 32767 : -32768;
      xi[k] = (k < H) ? -32768 : 32767;
    end
    run_frame(4'd15, "R6", "R6", 1'b0);
  endtask

  task automatic t_odd_with_junk();
    for (int k = 0; k < N; k++) begin
      xr[k] = ((k * 7) % 11) - 9;
      xi[k] = 5 - ((k * 5) % 13);
    end
    run_frame(4'd0, "R10", "R10", 1'b1);
  endtask

  task automatic t_after_junk();
    for (int k = 0; k < N; k++) begin
      xr[k] = 1000 - 333 * k;
      xi[k] = (k % 3) * 2001 - 1999;
    end
    run_frame(4'd3, "R10", "R10", 1'b0);
  endtask

  task automatic t_real_only();
    for (int k = 0; k < N; k++) begin
      xr[k] = (k * k * 129) % 4093 - 2000;
      xi[k] = 0;
    end
    run_frame(4'd9, "R2", "R3", 1'b0);
  endtask

  initial begin
    t_reset();
    t_ramp();
    t_full_scale();
    t_odd_with_junk();
    t_after_junk();
    t_real_only();
    repeat (3) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule